// File: doc/BRIEF.md
# Snapshot Scaler Bank with Timestamp

This block keeps one event counter per input channel together with a free-running timestamp. It is meant for rate measurement: every channel input is a synchronized pulse, one system clock wide, and each pulse that is accepted adds one to that channel's counter. A prescaler lets the timestamp advance once every `TS_DIV` system cycles. With the defaults this gives 20 MHz from a 100 MHz clock.

The host reaches the block through a simple word-addressed read/write strobe interface. A read of the timestamp slot returns the timestamp. In the same clock edge it also copies every channel counter into that channel's shadow register, so all channels are sampled at one instant. The host then reads the shadow registers one by one from a block of consecutive addresses. Software divides the change in a shadow value by the change in the timestamp to get a rate.

A write to the timestamp slot clears all live counters. Counting pauses for a short fixed window around each snapshot, and pulses that arrive in that window are dropped. This keeps the copy clean.

Top module: `snap_scaler_bank`

## Requirements
- R1: The timestamp starts at 0 after reset. It increases by exactly 1 on every `TS_DIV`-th clock edge (default 5), holds its value between those edges, and wraps from all ones to 0.
- R2: A read with `addr` equal to `TS_ADDR` (default 0) returns, one cycle later, the timestamp value present in the request cycle. At the same edge, every shadow register takes the value its live counter had before that edge.
- R3: A write with `addr` equal to `TS_ADDR` sets every live counter to 0 at that edge. A write to any other address has no effect.
- R4: A channel pulse is not counted at the snapshot edge, nor at the two edges that follow it (`INHIBIT_CYC` = 3 edges in total). A pulse at any other edge adds exactly 1.
- R5: A live counter at all ones that accepts a pulse becomes 0. It does not saturate.
- R6: Shadow registers are 0 after reset. They keep their value until the next snapshot, whatever happens on the inputs or to the live counters.
- R7: A read with `addr` = `CH_BASE + k` (default `CH_BASE` = 16) returns shadow register k. A read of an address that belongs to neither the timestamp nor a channel returns 0.
- R7 (timing): `rd_valid` is high exactly in the cycle after each read request, and `rdata` holds its value until the next read.
- R8: During and right after reset, `rd_valid` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CH | One-cycle synchronized event pulses, one bit per channel |
| rd_en | input | 1 | Host read request for `addr` |
| wr_en | input | 1 | Host write request for `addr` |
| addr | input | ADDR_W | Word address of the host access |
| rdata | output | DATA_W | Read data, updated one cycle after a read request |
| rd_valid | output | 1 | High in the cycle where `rdata` answers a read |

## Verification
Assertions check several things on every cycle:
- the timestamp holds between prescaler ticks, and ticks never occur back to back;
- a snapshot copies each counter and raises the inhibit on the next edge;
- a blocked counter does not move;
- a clear gives zero;
- the counter wraps from all ones to zero;
- a shadow holds when there is no snapshot;
- `rd_valid` follows the request.

Some behaviour can only be shown by the bench scenarios against its reference model:
- the exact number of pulses dropped around a snapshot;
- that a write to other addresses does not clear the counters;
- the read-address map, including unmapped holes;
- a full counter wrap and a timestamp wrap, seen through host reads.

// File: rtl/snap_scaler_pkg.sv
package snap_scaler_pkg;

   // Decoded target of a host read
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_TS   = 2'd1,
      RSEL_CH   = 2'd2
   } rd_sel_e;

   // Width of a down-counter that must hold values up to max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/snap_ts_gen.sv
module snap_ts_gen #(
   parameter int DATA_W = 32,
   parameter int TS_DIV = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [DATA_W-1:0] ts_o,
   output logic              tick_o
);

   generate
      if (TS_DIV < 1) begin : g_bad_div
         $error("snap_ts_gen: TS_DIV must be at least 1");
      end

      if (TS_DIV == 1) begin : g_nodiv
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(TS_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TS_DIV - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                        div_q <= div_q + 1'b1;
         end

         assign tick_o = (div_q == DIV_LAST);

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);  // R1
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ts_o <= '0;
      else if (tick_o) ts_o <= ts_o + 1'b1;
   end

   AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_o |=> $stable(ts_o));  // R1

endmodule

// File: rtl/snap_inhibit.sv
module snap_inhibit
   import snap_scaler_pkg::*;
#(
   parameter int INHIBIT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic snap_i,
   output logic block_o
);

   generate
      if (INHIBIT_CYC < 1) begin : g_bad_inh
         $error("snap_inhibit: INHIBIT_CYC must be at least 1");
      end

      if (INHIBIT_CYC == 1) begin : g_single
         assign block_o = snap_i;
      end else begin : g_window
         localparam int INH_W = cnt_width(INHIBIT_CYC - 1);
         logic [INH_W-1:0] left_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             left_q <= '0;
            else if (snap_i)        left_q <= INH_W'(INHIBIT_CYC - 1);
            else if (left_q != '0)  left_q <= left_q - 1'b1;
         end

         assign block_o = snap_i || (left_q != '0);

         AST_INHIBIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            snap_i |=> block_o);  // R4
      end
   endgenerate

endmodule

// File: rtl/snap_chan.sv
module snap_chan #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              block_i,
   input  logic              clr_i,
   input  logic              snap_i,
   output logic [DATA_W-1:0] count_o,
   output logic [DATA_W-1:0] shadow_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count_o <= '0;
      else if (clr_i)             count_o <= '0;
      else if (evt_i && !block_i) count_o <= count_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_o <= '0;
      else if (snap_i) shadow_o <= count_o;
   end

   AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (block_i && !clr_i) |=> $stable(count_o));  // R4
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (count_o == '0));  // R3
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((&count_o) && evt_i && !block_i && !clr_i) |=> (count_o == '0));  // R5
   AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      snap_i |=> (shadow_o == $past(count_o)));  // R2
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_i |=> $stable(shadow_o));  // R6

endmodule

// File: rtl/snap_scaler_bank.sv
module snap_scaler_bank
   import snap_scaler_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 6,
   parameter int TS_ADDR     = 0,
   parameter int CH_BASE     = 16,
   parameter int TS_DIV      = 5,
   parameter int INHIBIT_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_i,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid
);

   localparam int CH_LAST = CH_BASE + NUM_CH - 1;
   localparam logic [ADDR_W-1:0] TS_A = ADDR_W'(TS_ADDR);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("snap_scaler_bank: NUM_CH must be at least 1");
      end
      if (CH_LAST >= (1 << ADDR_W) || TS_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("snap_scaler_bank: address map does not fit ADDR_W");
      end
      if (TS_ADDR >= CH_BASE && TS_ADDR <= CH_LAST) begin : g_bad_overlap
         $error("snap_scaler_bank: timestamp slot overlaps channel block");
      end
   endgenerate

   logic              snap, clr, block, tick;
   logic [DATA_W-1:0] ts;
   logic [DATA_W-1:0] shadow [NUM_CH];
   logic [DATA_W-1:0] ch_val;
   rd_sel_e           rsel;

   assign snap = rd_en && (addr == TS_A);
   assign clr  = wr_en && (addr == TS_A);

   snap_ts_gen #(.DATA_W(DATA_W), .TS_DIV(TS_DIV)) i_ts (
      .clk(clk), .rst_n(rst_n), .ts_o(ts), .tick_o(tick)
   );

   snap_inhibit #(.INHIBIT_CYC(INHIBIT_CYC)) i_inh (
      .clk(clk), .rst_n(rst_n), .snap_i(snap), .block_o(block)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [DATA_W-1:0] live;
         snap_chan #(.DATA_W(DATA_W)) i_chan (
            .clk(clk), .rst_n(rst_n), .evt_i(evt_i[c]), .block_i(block),
            .clr_i(clr), .snap_i(snap), .count_o(live), .shadow_o(shadow[c])
         );
      end
   endgenerate

   // Read decode and channel mux
   always_comb begin
      rsel   = RSEL_NONE;
      ch_val = '0;
      if (addr == TS_A) rsel = RSEL_TS;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(CH_BASE + i)) begin
            rsel   = RSEL_CH;
            ch_val = shadow[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            unique case (rsel)
               RSEL_TS: rdata <= ts;
               RSEL_CH: rdata <= ch_val;
               default: rdata <= '0;
            endcase
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);  // R7
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!rd_valid && $stable(rdata)));  // R7
   AST_TS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (rdata == $past(ts)));  // R2

endmodule

// File: tb/test_snap_scaler_bank.sv
module test_snap_scaler_bank;

   localparam int NCH  = 8;
   localparam int DW   = 10;
   localparam int AW   = 6;
   localparam int BASE = 16;
   localparam int MOD  = 1 << DW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] evt_i = '0;
   logic           rd_en = 1'b0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [DW-1:0]  rdata;
   logic           rd_valid;

   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;
   string cur_req = "R8";

   always #5 clk = ~clk;

   snap_scaler_bank #(
      .NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW), .TS_ADDR(0),
      .CH_BASE(BASE), .TS_DIV(5), .INHIBIT_CYC(3)
   ) i_snap_scaler_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .rdata(rdata), .rd_valid(rd_valid)
   );

   // Behavioural reference model
   int m_cnt [NCH];
   int m_sh  [NCH];
   int m_ts, m_div, m_inh, exp_rdata;
   bit exp_valid;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_cnt[i]) begin m_cnt[i] = 0; m_sh[i] = 0; end
         m_ts = 0; m_div = 0; m_inh = 0; exp_rdata = 0; exp_valid = 0;
      end else begin
         bit snap_m, clr_m, blk_m;
         snap_m = rd_en && (addr == 0);
         clr_m  = wr_en && (addr == 0);
         blk_m  = snap_m || (m_inh > 0);
         exp_valid = rd_en;
         if (rd_en) begin
            if (addr == 0)                             exp_rdata = m_ts;
            else if (addr >= BASE && addr < BASE + NCH) exp_rdata = m_sh[addr - BASE];
            else                                        exp_rdata = 0;
         end
         if (snap_m) foreach (m_sh[i]) m_sh[i] = m_cnt[i];
         foreach (m_cnt[i]) begin
            if (clr_m)                   m_cnt[i] = 0;
            else if (!blk_m && evt_i[i]) m_cnt[i] = (m_cnt[i] + 1) % MOD;
         end
         if (snap_m)         m_inh = 2;
         else if (m_inh > 0) m_inh = m_inh - 1;
         if (m_div == 4) begin m_div = 0; m_ts = (m_ts + 1) % MOD; end
         else m_div = m_div + 1;
      end
   end

   // Compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         checks++;
         if (rd_valid !== exp_valid) begin
            failures++;
            $display("FAIL R7 rd_valid actual=%0b expected=%0b t=%0t", rd_valid, exp_valid, $time);
         end
         checks++;
         if (rdata !== DW'(exp_rdata)) begin
            failures++;
            $display("FAIL %s rdata actual=%0d expected=%0d t=%0t", cur_req, rdata, exp_rdata, $time);
         end
      end
   end

   task automatic cyc(input bit r, input bit w, input int a, input logic [NCH-1:0] e);
      @(negedge clk);
      rd_en = r; wr_en = w; addr = AW'(a); evt_i = e;
   endtask

   task automatic idle(input int n, input bit rnd);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, rnd ? NCH'($urandom) : '0);
   endtask

   task automatic snap_and_dump();
      cyc(1, 0, 0, '0);
      for (int k = 0; k < NCH; k++) cyc(1, 0, BASE + k, '0);
      cyc(0, 0, 0, '0);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2, 0);

      // R1: timestamp progress at several phases
      cur_req = "R1";
      for (int j = 0; j < 6; j++) begin
         idle(j + 2, 0);
         cyc(1, 0, 0, '0);
      end

      // R2 / R7: random events, snapshot, channel and unmapped reads
      cur_req = "R2";
      idle(300, 1);
      snap_and_dump();
      cur_req = "R7";
      for (int a = 1; a < BASE; a++) cyc(1, 0, a, '0);
      for (int a = BASE + NCH; a < 64; a++) cyc(1, 0, a, '0);

      // R4: continuous pulses across the inhibit window
      cur_req = "R4";
      idle(2, 0);
      cyc(0, 0, 0, '1); cyc(0, 0, 0, '1);
      cyc(1, 0, 0, '1);
      for (int i = 0; i < 6; i++) cyc(0, 0, 0, '1);
      snap_and_dump();
      cyc(1, 0, 0, '1); cyc(1, 0, 0, '1); cyc(0, 0, 0, '1);
      snap_and_dump();

      // R3: write elsewhere ignored, write to timestamp slot clears
      cur_req = "R3";
      idle(50, 1);
      cyc(0, 1, BASE, '0); cyc(0, 1, 5, '1);
      snap_and_dump();
      idle(20, 1);
      cyc(0, 1, 0, '1);
      snap_and_dump();

      // R6: shadows hold while counters move
      cur_req = "R6";
      idle(100, 1);
      for (int k = 0; k < NCH; k++) cyc(1, 0, BASE + k, NCH'($urandom));
      cyc(0, 1, 0, '0);
      for (int k = 0; k < NCH; k++) cyc(1, 0, BASE + k, '0);

      // R5: counter wrap on channel 0
      cur_req = "R5";
      cyc(0, 1, 0, '0);
      for (int i = 0; i < MOD - 3; i++) cyc(0, 0, 0, NCH'(1));
      snap_and_dump();
      idle(4, 0);
      for (int i = 0; i < 10; i++) cyc(0, 0, 0, NCH'(1));
      snap_and_dump();

      // R1: timestamp wrap
      cur_req = "R1";
      for (int j = 0; j < 6; j++) begin
         idle(1200, 0);
         cyc(1, 0, 0, '0);
      end
      idle(3, 0);
      finish_run();
   end

endmodule